// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target on a Two-Wire Bus

This block acts as a target on a two-wire serial bus (I2C signalling) and behaves like a small byte-addressed EEPROM. It oversamples the clock and data lines with a fast system clock and recognises START and STOP conditions. It shifts in a device-select byte, and then either takes a word address followed by data bytes to store, or returns stored bytes one after another. The data line is driven open-drain: the block only ever asserts an enable that pulls the line low.

The array holds a power-of-two number of bytes. When the array is larger than 256 bytes, the address bits above bit 7 come from spare bits of the device-select byte, gated by a mask parameter. A run of written bytes stays inside one 16-byte page and wraps at the page boundary. A run of read bytes walks through the whole array and wraps from the last byte to byte 0. A read that follows a repeated START uses the pointer left by the earlier word address. This gives the usual random-read sequence.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe_o` is 0 and the target is idle.
- R2: SDA falling while SCL is high (START) aborts any transfer in progress and begins a new device-select byte. SDA rising while SCL is high (STOP) returns to idle. In idle, clock pulses are ignored and SDA is never pulled.
- R3: The 8-bit device-select byte is accepted when `(byte & DEV_MASK) == (DEV_MATCH & DEV_MASK)`, with defaults 0xA0 and 0xF0. On a mismatch the target does not acknowledge and stays silent until the next START.
- R4: After every accepted byte written by the master (device select, word address and data), the target pulls SDA low for the ninth clock. It starts pulling at the falling edge that ends the eighth bit and releases at the falling edge that ends the ninth. `sda_oe_o` only changes after an SCL fall, a START or a STOP.
- R5: In a device-select byte with bit 0 = 0, bits [3:1] ANDed with `HI_MASK` become memory address bits [10:8], truncated to the array width. The following word-address byte supplies bits [7:0].
- R6: Each data byte written after the word address is stored at the pointer. The pointer then increments only in its low 4 bits (16-byte page), and its upper bits stay fixed.
- R7: A device-select byte with bit 0 = 1 makes the target send the byte at the pointer, MSB first. Each bit is driven from the SCL falling edge before its clock pulse. The pointer then increments modulo the array size (0x1FF is followed by 0x000 at 512 bytes).
- R8: After each sent byte, the master's ninth bit is sampled on the SCL rise. A 0 makes the target send the next byte. A 1 makes it release SDA and stay silent until the next START.
- R9: A read that follows a repeated START begins at the pointer set by the preceding word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach from the pins is a sequential read that crosses the end of the array. The pointer must sit on the very last byte, and that needs a device-select byte whose spare bits carry the upper address. The bench writes a marker there through the high half of the array, sets the pointer back to that byte, issues a repeated START in the read direction and acknowledges once. The second byte must then come from address 0. The same sequence is extended past a NACK with extra clock pulses to show that the target stays silent.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  // Bit-level bus position of the target.
  typedef enum logic [2:0] {
    ST_IDLE,     // waiting for START
    ST_RX,       // shifting in a byte from the master
    ST_RX_DONE,  // eight bits in, decide on the falling edge
    ST_RX_ACK,   // target pulls SDA for the ninth clock
    ST_TX,       // shifting a byte out to the master
    ST_TX_ACK,   // waiting for the master's ninth bit
    ST_TX_NEXT,  // master acknowledged, load next byte on fall
    ST_NACKED    // master refused, silent until START
  } bus_state_t;

  // Meaning of the next byte within a transfer.
  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_WDATA,
    PH_READ
  } phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  // Idle bus level is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~pipe_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      cells[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int         MEM_BYTES   = 512,
  parameter int         PAGE_BYTES  = 16,
  parameter logic [7:0] DEV_MATCH   = 8'hA0,
  parameter logic [7:0] DEV_MASK    = 8'hF0,
  parameter logic [2:0] HI_MASK     = 3'b001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int          AW    = $clog2(MEM_BYTES);
  localparam int          PW    = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Line synchronisers, index 0 = SCL, 1 = SDA.
  logic [1:0] line_in, line_lvl, line_rise, line_fall;
  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .line_i (line_in[g]),
      .level_o(line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, bus_start, bus_stop;
  assign scl_lvl   = line_lvl[0];
  assign scl_rise  = line_rise[0];
  assign scl_fall  = line_fall[0];
  assign sda_lvl   = line_lvl[1];
  assign bus_start = line_fall[1] & scl_lvl;
  assign bus_stop  = line_rise[1] & scl_lvl;

  // State
  bus_state_t    st_q, st_d;
  phase_t        ph_q, ph_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [2:0]    hi_q, hi_d;
  logic          oe_q, oe_d;
  logic          mem_we, tx_load, dev_reject, dev_hit;
  logic [7:0]    rd_data;
  logic [10:0]   ext_addr;
  logic [AW-1:0] word_addr, page_next;

  assign dev_hit   = ((sh_q & DEV_MASK) == (DEV_MATCH & DEV_MASK));
  assign ext_addr  = {hi_q, sh_q};
  assign word_addr = AW'(ext_addr);
  assign page_next = (addr_q & ~PMASK) | (AW'(addr_q + 1'b1) & PMASK);

  i2c_mem_store #(.DEPTH(MEM_BYTES), .AW(AW)) store_i (
    .clk    (clk),
    .we_i   (mem_we),
    .waddr_i(addr_q),
    .wdata_i(sh_q),
    .raddr_i(addr_q),
    .rdata_o(rd_data)
  );

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    addr_d     = addr_q;
    hi_d       = hi_q;
    oe_d       = oe_q;
    mem_we     = 1'b0;
    tx_load    = 1'b0;
    dev_reject = 1'b0;
    if (bus_start) begin
      st_d  = ST_RX;
      ph_d  = PH_DEV;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (bus_stop) begin
      st_d = ST_IDLE;
      ph_d = PH_DEV;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: if (scl_rise) begin
          sh_d  = {sh_q[6:0], sda_lvl};
          cnt_d = 3'(cnt_q + 1'b1);
          if (cnt_q == 3'd7) st_d = ST_RX_DONE;
        end
        ST_RX_DONE: if (scl_fall) begin
          st_d = ST_RX_ACK;
          oe_d = 1'b1;
          unique case (ph_q)
            PH_DEV: begin
              if (dev_hit) begin
                ph_d = sh_q[0] ? PH_READ : PH_WORD;
                if (!sh_q[0]) hi_d = sh_q[3:1] & HI_MASK;
              end else begin
                dev_reject = 1'b1;
                st_d       = ST_IDLE;
                oe_d       = 1'b0;
              end
            end
            PH_WORD: begin
              addr_d = word_addr;
              ph_d   = PH_WDATA;
            end
            default: begin
              mem_we = 1'b1;
              addr_d = page_next;
            end
          endcase
        end
        ST_RX_ACK: if (scl_fall) begin
          oe_d  = 1'b0;
          cnt_d = '0;
          if (ph_q == PH_READ) tx_load = 1'b1;
          else                 st_d    = ST_RX;
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == 3'd7) begin
            oe_d = 1'b0;
            st_d = ST_TX_ACK;
          end else begin
            sh_d  = {sh_q[6:0], 1'b0};
            oe_d  = ~sh_q[6];
            cnt_d = 3'(cnt_q + 1'b1);
          end
        end
        ST_TX_ACK: if (scl_rise) begin
          st_d = sda_lvl ? ST_NACKED : ST_TX_NEXT;
        end
        ST_TX_NEXT: if (scl_fall) begin
          tx_load = 1'b1;
        end
        default: ;
      endcase
      if (tx_load) begin
        sh_d   = rd_data;
        oe_d   = ~rd_data[7];
        addr_d = AW'(addr_q + 1'b1);
        cnt_d  = '0;
        st_d   = ST_TX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_DEV;
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      hi_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      addr_q <= addr_d;
      hi_q   <= hi_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_mem_pkg::*;
#(
  parameter int AW = 9,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe_o,
  input logic          scl_fall,
  input logic          bus_start,
  input logic          bus_stop,
  input bus_state_t    st,
  input logic          mem_we,
  input logic          tx_load,
  input logic          dev_reject,
  input logic [AW-1:0] addr
);

  // R2: idle target never pulls the line
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);

  // R3: rejected device select leaves the target idle and silent
  p_reject_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reject |=> (st == ST_IDLE) && !sda_oe_o);

  // R4: the drive changes only behind an SCL fall, START or STOP
  p_oe_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall | bus_start | bus_stop));

  // R6: a stored byte advances the pointer inside its page only
  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr[AW-1:PW] == $past(addr[AW-1:PW])) &&
               (addr[PW-1:0] == PW'($past(addr[PW-1:0]) + 1'b1)));

  // R7: each fetched byte advances the pointer across the whole array
  p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> addr == AW'($past(addr) + 1'b1));

  // R8: after a refusal the target stays silent
  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NACKED) |-> !sda_oe_o);

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW), .PW(PW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe_o  (sda_oe_o),
  .scl_fall  (scl_fall),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .st        (st_q),
  .mem_we    (mem_we),
  .tx_load   (tx_load),
  .dev_reject(dev_reject),
  .addr      (addr_q)
);

// File: tb/i2c_mem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_target_tb_top;

  localparam int Q = 10;  // system clocks per quarter bit

  logic clk, rst_n, scl_m, sda_m, sda_oe_o;
  wire  sda_line = sda_m & ~sda_oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_byte;
  event       rx_ev;

  i2c_mem_target dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wq(); sda_m = 1'b1; wq();
    scl_m = 1'b1; wq(); sda_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wq(); sda_m = 1'b0; wq();
    scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    scl_m = 1'b0; wq(); sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    scl_m = 1'b0; wq(); sda_m = 1'b1; wq();
    scl_m = 1'b1; wq(); ack = sda_line; wq();
  endtask

  task automatic get_byte(input logic refuse, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wq(); sda_m = 1'b1; wq();
      scl_m = 1'b1; wq(); b[i] = sda_line; wq();
    end
    scl_m = 1'b0; wq(); sda_m = refuse; wq();
    scl_m = 1'b1; wq(); wq();
  endtask

  // Driver side of the scoreboard: push expectation, then clock the byte.
  task automatic expect_rd(input logic [7:0] e, input string tag, input logic refuse);
    logic [7:0] got;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    get_byte(refuse, got);
    rx_byte = got;
    -> rx_ev;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b, input string tag);
    logic ack;
    put_byte(b, ack);
    check(ack == 1'b0, tag, ack, 0);
  endtask

  // Monitor side: compare every byte the target returned.
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", rx_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rx_byte == e, t, rx_byte, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    repeat (10) @(negedge clk);
    check(sda_oe_o == 1'b0, "R1", sda_oe_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe_o == 1'b0, "R1", sda_oe_o, 0);

    // R3: wrong device select is refused, following byte also ignored
    bus_start();
    put_byte(8'hB0, ack); check(ack == 1'b1, "R3", ack, 1);
    put_byte(8'h00, ack); check(ack == 1'b1, "R3", ack, 1);
    bus_stop();

    // R2: clocks in idle are ignored
    put_byte(8'hA0, ack); check(ack == 1'b1, "R2", ack, 1);

    // R4: write four bytes at 0x05
    bus_start(); wr(8'hA0, "R4"); wr(8'h05, "R4");
    wr(8'h11, "R4"); wr(8'h22, "R4"); wr(8'h33, "R4"); wr(8'h44, "R4");
    bus_stop();

    // R9 / R7: random read via repeated START
    bus_start(); wr(8'hA0, "R4"); wr(8'h05, "R4");
    bus_start(); wr(8'hA1, "R4");
    expect_rd(8'h11, "R9", 1'b0); expect_rd(8'h22, "R7", 1'b0);
    expect_rd(8'h33, "R7", 1'b0); expect_rd(8'h44, "R8", 1'b1);
    bus_stop();

    // R6: page wrap on write
    bus_start(); wr(8'hA0, "R4"); wr(8'h10, "R4"); wr(8'h55, "R6"); bus_stop();
    bus_start(); wr(8'hA0, "R4"); wr(8'h0E, "R4");
    wr(8'hAA, "R6"); wr(8'hBB, "R6"); wr(8'hCC, "R6"); bus_stop();
    bus_start(); wr(8'hA0, "R4"); wr(8'h00, "R4"); bus_start(); wr(8'hA1, "R4");
    expect_rd(8'hCC, "R6", 1'b1); bus_stop();
    bus_start(); wr(8'hA0, "R4"); wr(8'h0E, "R4"); bus_start(); wr(8'hA1, "R4");
    expect_rd(8'hAA, "R6", 1'b0); expect_rd(8'hBB, "R6", 1'b0);
    expect_rd(8'h55, "R6", 1'b1); bus_stop();

    // R5: high address bit from device select, masked
    bus_start(); wr(8'hA2, "R5"); wr(8'h05, "R5"); wr(8'h77, "R5"); bus_stop();
    bus_start(); wr(8'hA2, "R5"); wr(8'h05, "R5"); bus_start(); wr(8'hA3, "R5");
    expect_rd(8'h77, "R5", 1'b1); bus_stop();
    bus_start(); wr(8'hA4, "R5"); wr(8'h05, "R5"); bus_start(); wr(8'hA5, "R5");
    expect_rd(8'h11, "R5", 1'b1); bus_stop();

    // R7: read crosses the end of the array
    bus_start(); wr(8'hA2, "R5"); wr(8'hFF, "R5"); wr(8'h99, "R6"); bus_stop();
    bus_start(); wr(8'hA2, "R5"); wr(8'hFF, "R5"); bus_start(); wr(8'hA1, "R7");
    expect_rd(8'h99, "R7", 1'b0); expect_rd(8'hCC, "R7", 1'b1);
    // R8: after refusal, further clocks return released line
    expect_rd(8'hFF, "R8", 1'b1);
    check(sda_oe_o == 1'b0, "R8", sda_oe_o, 0);
    bus_stop();

    // R2: START in the middle of a byte restarts cleanly
    bus_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start(); wr(8'hA0, "R2"); wr(8'h06, "R2");
    bus_start(); wr(8'hA1, "R2");
    expect_rd(8'h22, "R2", 1'b1); bus_stop();

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule